// File: doc/BRIEF.md
# Conditional Accumulator Modify Unit

This block is the execute stage for the "modify accumulator" operation of a 16-bit DSP core. It holds a 32-bit accumulator and a 16-bit status word. When a modify instruction word arrives, the unit evaluates a condition against one status flag. If the condition holds, it applies one of four single-step transforms to the accumulator and then refreshes the flags from the new value.

A separate load path writes the accumulator directly and leaves every flag alone. Instruction words whose condition code or operation code the unit does not implement are rejected. A rejected word changes nothing and raises a one-cycle illegal-op pulse, which the surrounding core can trap on. Fetch, the multiplier and memory operands are handled elsewhere. All state changes take effect at the rising clock edge after the request.

Top module: `acc_modify_unit`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, the status word and the illegal-op output to zero.
- R2: With `load_valid` high, the accumulator takes `load_data` at the next edge, and the status word does not change.
- R3: The condition code is `mod_word[7:4]`. Code 0x0 is always true. Code 0x5 is true when Z (status bit 13) equals the polarity bit `mod_word[8]`. Code 0x7 is true when N (status bit 15) equals `mod_word[8]`.
- R4: A modify whose condition is false leaves the accumulator and the status word unchanged and does not raise illegal-op.
- R5: Operation code `mod_word[2:0]` = 2 shifts the accumulator right by one bit, copying bit 31 into the vacated bit.
- R6: Operation code 3 shifts the accumulator left by one bit and fills bit 0 with zero.
- R7: Operation code 6 replaces the accumulator with its two's-complement negation, modulo 2^32.
- R8: Operation code 7 negates the accumulator only when bit 31 is set. The value 0x80000000 stays 0x80000000.
- R9: After a performed modify, Z (bit 13) is 1 exactly when the 32-bit result is zero, N (bit 15) equals result bit 31, and L (bit 12) and V (bit 14) are 0. Status bits 11:0 stay zero.
- R10: A modify with a condition code other than 0x0, 0x5 or 0x7, or an operation code other than 2, 3, 6 or 7, leaves the accumulator and status unchanged and sets `illegal_q` for the following cycle only.
- R11: When `load_valid` and `mod_valid` are high in the same cycle, the load is performed. The modify has no effect on the accumulator or the flags and raises no illegal-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | Request a plain accumulator load |
| load_data | input | 32 | Value for the accumulator load |
| mod_valid | input | 1 | Request a conditional modify |
| mod_word | input | 16 | Modify instruction word (polarity, condition and operation fields) |
| acc_q | output | 32 | Current accumulator value |
| status_q | output | 16 | Current status word (N, V, Z, L in bits 15..12) |
| illegal_q | output | 1 | One-cycle pulse after a rejected modify |

## Verification
The load path and the modify path can both be requested in one cycle. Their collision decides which value the accumulator holds and whether the flags move. The bench provokes this by asserting both requests together. It does so once with a legal negate word, which would otherwise change both the accumulator and N, and once with an unimplemented word, which would otherwise raise illegal-op. It then judges the outcome from the loaded value, the unchanged status word and a low illegal-op output on the following cycle.

// File: rtl/amu_pkg.sv
// Package: shared encodings for the conditional accumulator modify unit.
// Assumes the status word is at least 16 bits wide so all flag positions exist.
package amu_pkg;

    // Positions of the flags inside the status word
    localparam int unsigned FLAG_L_POS = 12;
    localparam int unsigned FLAG_Z_POS = 13;
    localparam int unsigned FLAG_V_POS = 14;
    localparam int unsigned FLAG_N_POS = 15;

    // Fields of the modify instruction word
    localparam int unsigned POL_POS    = 8;
    localparam int unsigned COND_LSB   = 4;
    localparam int unsigned COND_W     = 4;
    localparam int unsigned OPSEL_LSB  = 0;
    localparam int unsigned OPSEL_W    = 3;

    // Implemented condition codes
    typedef enum logic [COND_W-1:0] {
        CC_ALWAYS = 4'h0,
        CC_ZFLAG  = 4'h5,
        CC_NFLAG  = 4'h7
    } cond_code_e;

    // Implemented modify operations
    typedef enum logic [OPSEL_W-1:0] {
        OP_ASR = 3'd2,
        OP_SHL = 3'd3,
        OP_NEG = 3'd6,
        OP_ABS = 3'd7
    } mod_op_e;

endpackage

// File: rtl/amu_cond_eval.sv
// Module: amu_cond_eval
// Decides whether a modify instruction's condition holds. It compares one
// selected flag with the polarity bit of the instruction word.
// Assumes flags arrive from the registered status word (purely combinational).
module amu_cond_eval
    import amu_pkg::*;
(
    input  logic [COND_W-1:0] cond_field,
    input  logic              polarity,
    input  logic              flag_z,
    input  logic              flag_n,
    output logic              cond_known,
    output logic              cond_true
);

    // Decode the condition code and evaluate it against the chosen flag
    always_comb begin
        cond_known = 1'b1;
        cond_true  = 1'b0;
        case (cond_field)
            CC_ALWAYS: cond_true = 1'b1;
            CC_ZFLAG:  cond_true = (flag_z == polarity);
            CC_NFLAG:  cond_true = (flag_n == polarity);
            default: begin
                cond_known = 1'b0;
                cond_true  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/amu_shift_unit.sv
// Module: amu_shift_unit
// Computes the candidate new accumulator for each modify operation.
// Absolute value reuses the negation result, so a single subtractor serves both.
// Assumes ACC_W >= 2.
module amu_shift_unit
    import amu_pkg::*;
#(
    parameter int unsigned ACC_W = 32
) (
    input  logic [ACC_W-1:0]   acc_in,
    input  logic [OPSEL_W-1:0] op_field,
    output logic [ACC_W-1:0]   acc_res,
    output logic               op_known
);

    localparam int unsigned MSB = ACC_W - 1;

    logic [ACC_W-1:0] negated;
    logic [ACC_W-1:0] asr_val;
    logic [ACC_W-1:0] shl_val;

    // Shared two's-complement negation
    always_comb negated = '0 - acc_in;

    // Shift candidates: sign-filling right, zero-filling left
    always_comb begin
        asr_val = {acc_in[MSB], acc_in[MSB:1]};
        shl_val = {acc_in[MSB-1:0], 1'b0};
    end

    // Select the result for the requested operation
    always_comb begin
        op_known = 1'b1;
        acc_res  = acc_in;
        case (op_field)
            OP_ASR: acc_res = asr_val;
            OP_SHL: acc_res = shl_val;
            OP_NEG: acc_res = negated;
            OP_ABS: acc_res = acc_in[MSB] ? negated : acc_in;
            default: begin
                op_known = 1'b0;
                acc_res  = acc_in;
            end
        endcase
    end

endmodule

// File: rtl/amu_flag_gen.sv
// Module: amu_flag_gen
// Builds the status word that follows a performed modify. Z and N come from
// the result, L and V are cleared, and the other bits pass through.
// Assumes ST_W > FLAG_N_POS.
module amu_flag_gen
    import amu_pkg::*;
#(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned ST_W  = 16
) (
    input  logic [ST_W-1:0]  st_in,
    input  logic [ACC_W-1:0] acc_res,
    output logic [ST_W-1:0]  st_res
);

    localparam int unsigned MSB = ACC_W - 1;

    logic res_zero;

    // Zero detect over the full accumulator
    always_comb res_zero = (acc_res == '0);

    // Merge the refreshed flags into the status word, bit by bit
    for (genvar b = 0; b < ST_W; b++) begin : g_bit
        if (b == FLAG_Z_POS) begin : g_z
            assign st_res[b] = res_zero;
        end else if (b == FLAG_N_POS) begin : g_n
            assign st_res[b] = acc_res[MSB];
        end else if (b == FLAG_L_POS || b == FLAG_V_POS) begin : g_clr
            assign st_res[b] = 1'b0;
        end else begin : g_keep
            assign st_res[b] = st_in[b];
        end
    end

endmodule

// File: rtl/acc_modify_unit.sv
// Module: acc_modify_unit (top)
// Registers the accumulator, status word and illegal-op pulse. A load has
// priority over a modify issued in the same cycle. A modify is applied only
// when both its fields are implemented and its condition holds.
// Assumes one request of each kind per cycle at most; the reset is synchronous.
module acc_modify_unit
    import amu_pkg::*;
#(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned ST_W  = 16,
    parameter int unsigned OPC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_valid,
    input  logic [ACC_W-1:0] load_data,
    input  logic             mod_valid,
    input  logic [OPC_W-1:0] mod_word,
    output logic [ACC_W-1:0] acc_q,
    output logic [ST_W-1:0]  status_q,
    output logic             illegal_q
);

    logic [COND_W-1:0]  cond_field;
    logic [OPSEL_W-1:0] op_field;
    logic               polarity;
    logic               cond_known;
    logic               cond_true;
    logic               op_known;
    logic [ACC_W-1:0]   acc_res;
    logic [ST_W-1:0]    st_res;
    logic               unused_opc_bits;

    // Split the instruction word into its fields
    always_comb begin
        cond_field = mod_word[COND_LSB +: COND_W];
        op_field   = mod_word[OPSEL_LSB +: OPSEL_W];
        polarity   = mod_word[POL_POS];
    end

    // Bits of the instruction word that this stage does not decode
    assign unused_opc_bits = ^{mod_word[OPC_W-1:POL_POS+1], mod_word[COND_LSB-1:OPSEL_W]};

    amu_cond_eval u_cond (
        .cond_field (cond_field),
        .polarity   (polarity),
        .flag_z     (status_q[FLAG_Z_POS]),
        .flag_n     (status_q[FLAG_N_POS]),
        .cond_known (cond_known),
        .cond_true  (cond_true)
    );

    amu_shift_unit #(.ACC_W(ACC_W)) u_shift (
        .acc_in   (acc_q),
        .op_field (op_field),
        .acc_res  (acc_res),
        .op_known (op_known)
    );

    amu_flag_gen #(.ACC_W(ACC_W), .ST_W(ST_W)) u_flags (
        .st_in   (status_q),
        .acc_res (acc_res),
        .st_res  (st_res)
    );

    // State update: reset, then load priority, then legal/illegal modify
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            status_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            if (load_valid) begin
                acc_q <= load_data;
            end else if (mod_valid) begin
                if (!(cond_known && op_known)) begin
                    illegal_q <= 1'b1;
                end else if (cond_true) begin
                    acc_q    <= acc_res;
                    status_q <= st_res;
                end
            end
        end
    end

endmodule

// File: rtl/amu_checker.sv
// Module: amu_checker
// Temporal properties of acc_modify_unit, observed at its ports and state.
module amu_checker
    import amu_pkg::*;
#(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned ST_W  = 16,
    parameter int unsigned OPC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_valid,
    input logic [ACC_W-1:0] load_data,
    input logic             mod_valid,
    input logic [OPC_W-1:0] mod_word,
    input logic [ACC_W-1:0] acc_q,
    input logic [ST_W-1:0]  status_q,
    input logic             illegal_q
);

    logic unused_chk;
    assign unused_chk = ^mod_word;

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_valid)) |-> (acc_q == $past(load_data)));

    // R2
    load_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_valid)) |-> (status_q == $past(status_q)));

    // R10
    illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> ($past(mod_valid) && !$past(load_valid)));

    // R10
    illegal_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> (acc_q == $past(acc_q) && status_q == $past(status_q)));

    // R9
    lv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q[FLAG_L_POS] && !status_q[FLAG_V_POS] && status_q[11:0] == '0));

    // R9
    zn_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mod_valid) && !$past(load_valid) && acc_q != $past(acc_q))
        |-> (status_q[FLAG_Z_POS] == (acc_q == '0) && status_q[FLAG_N_POS] == acc_q[ACC_W-1]));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_valid) && !$past(mod_valid))
        |-> (acc_q == $past(acc_q) && status_q == $past(status_q) && !illegal_q));

endmodule

bind acc_modify_unit amu_checker #(.ACC_W(ACC_W), .ST_W(ST_W), .OPC_W(OPC_W)) u_amu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_data  (load_data),
    .mod_valid  (mod_valid),
    .mod_word   (mod_word),
    .acc_q      (acc_q),
    .status_q   (status_q),
    .illegal_q  (illegal_q)
);

// File: tb/sim_acc_modify_unit.sv
`timescale 1ns/1ps
module sim_acc_modify_unit;

    typedef struct packed {
        logic        ld;
        logic [31:0] d;
        logic        md;
        logic [15:0] op;
        logic [31:0] ea;
        logic [15:0] es;
        logic        ei;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 32'h00000010, 1'b0, 16'h0000, 32'h00000010, 16'h0000, 1'b0, 8'd2},  // R2 load
        '{1'b0, 32'h0,        1'b1, 16'h0002, 32'h00000008, 16'h0000, 1'b0, 8'd5},  // R5 asr
        '{1'b0, 32'h0,        1'b1, 16'h0003, 32'h00000010, 16'h0000, 1'b0, 8'd6},  // R6 shl
        '{1'b0, 32'h0,        1'b1, 16'h0006, 32'hFFFFFFF0, 16'h8000, 1'b0, 8'd7},  // R7 neg
        '{1'b0, 32'h0,        1'b1, 16'h0002, 32'hFFFFFFF8, 16'h8000, 1'b0, 8'd5},  // R5 sign fill
        '{1'b0, 32'h0,        1'b1, 16'h0007, 32'h00000008, 16'h0000, 1'b0, 8'd8},  // R8 abs neg
        '{1'b0, 32'h0,        1'b1, 16'h0007, 32'h00000008, 16'h0000, 1'b0, 8'd8},  // R8 abs pos
        '{1'b1, 32'h80000000, 1'b0, 16'h0000, 32'h80000000, 16'h0000, 1'b0, 8'd2},  // R2 flags kept
        '{1'b0, 32'h0,        1'b1, 16'h0007, 32'h80000000, 16'h8000, 1'b0, 8'd8},  // R8 most negative
        '{1'b0, 32'h0,        1'b1, 16'h0003, 32'h00000000, 16'h2000, 1'b0, 8'd9},  // R9 zero result
        '{1'b1, 32'h00000005, 1'b0, 16'h0000, 32'h00000005, 16'h2000, 1'b0, 8'd2},  // R2 Z kept
        '{1'b0, 32'h0,        1'b1, 16'h0153, 32'h0000000A, 16'h0000, 1'b0, 8'd3},  // R3 Z==1 true
        '{1'b0, 32'h0,        1'b1, 16'h0153, 32'h0000000A, 16'h0000, 1'b0, 8'd4},  // R4 Z==1 false
        '{1'b0, 32'h0,        1'b1, 16'h0056, 32'hFFFFFFF6, 16'h8000, 1'b0, 8'd3},  // R3 Z==0 true
        '{1'b0, 32'h0,        1'b1, 16'h0072, 32'hFFFFFFF6, 16'h8000, 1'b0, 8'd4},  // R4 N==0 false
        '{1'b0, 32'h0,        1'b1, 16'h0172, 32'hFFFFFFFB, 16'h8000, 1'b0, 8'd3},  // R3 N==1 true
        '{1'b0, 32'h0,        1'b1, 16'h0004, 32'hFFFFFFFB, 16'h8000, 1'b1, 8'd10}, // R10 bad op
        '{1'b0, 32'h0,        1'b0, 16'h0000, 32'hFFFFFFFB, 16'h8000, 1'b0, 8'd10}, // R10 pulse ends
        '{1'b0, 32'h0,        1'b1, 16'h0032, 32'hFFFFFFFB, 16'h8000, 1'b1, 8'd10}, // R10 bad cond
        '{1'b1, 32'h00000003, 1'b1, 16'h0006, 32'h00000003, 16'h8000, 1'b0, 8'd11}, // R11 load wins
        '{1'b1, 32'h00000007, 1'b1, 16'h0004, 32'h00000007, 16'h8000, 1'b0, 8'd11}, // R11 no illegal
        '{1'b0, 32'h0,        1'b1, 16'h0006, 32'hFFFFFFF9, 16'h8000, 1'b0, 8'd7}   // R7 neg again
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [31:0] load_data = '0;
    logic        mod_valid = 1'b0;
    logic [15:0] mod_word = '0;
    logic [31:0] acc_q;
    logic [15:0] status_q;
    logic        illegal_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acc_modify_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_data  (load_data),
        .mod_valid  (mod_valid),
        .mod_word   (mod_word),
        .acc_q      (acc_q),
        .status_q   (status_q),
        .illegal_q  (illegal_q)
    );

    task automatic check(string tag, logic [31:0] ea, logic [15:0] es, logic ei);
        checks++;
        if (acc_q !== ea || status_q !== es || illegal_q !== ei) begin
            errors++;
            $display("FAIL %s: acc=%h st=%h ill=%b expected acc=%h st=%h ill=%b",
                     tag, acc_q, status_q, illegal_q, ea, es, ei);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample 2 ns later
    task automatic step(logic ld, logic [31:0] d, logic md, logic [15:0] op);
        @(negedge clk);
        load_valid = ld;
        load_data  = d;
        mod_valid  = md;
        mod_word   = op;
        @(posedge clk);
        #2;
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #2;
        check("R1 reset", 32'h0, 16'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ld, VECS[i].d, VECS[i].md, VECS[i].op);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].ea, VECS[i].es, VECS[i].ei);
        end

        // R1: reset wins over a pending modify
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b0, 32'h0, 1'b1, 16'h0004);
        check("R1 mid-run reset", 32'h0, 16'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 and R9: negating zero yields zero with Z set
        step(1'b0, 32'h0, 1'b1, 16'h0006);
        check("R7 neg zero", 32'h0, 16'h2000, 1'b0);
        // R5: shifting zero right keeps it zero
        step(1'b0, 32'h0, 1'b1, 16'h0002);
        check("R5 asr zero", 32'h0, 16'h2000, 1'b0);
        // R10: operation code 0 is rejected, pulse then clears
        step(1'b0, 32'h0, 1'b1, 16'h0000);
        check("R10 op zero", 32'h0, 16'h2000, 1'b1);
        step(1'b0, 32'h0, 1'b0, 16'h0000);
        check("R10 pulse one cycle", 32'h0, 16'h2000, 1'b0);
        // R6: left shift drops bit 31
        step(1'b1, 32'hC0000001, 1'b0, 16'h0000);
        step(1'b0, 32'h0, 1'b1, 16'h0003);
        check("R6 shl top bit", 32'h80000002, 16'h8000, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule